// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog Timer

This block is a watchdog that sits on a simple 32-bit register bus. A built-in tick generator divides a 1 MHz enable strobe by a programmable reload value, and each of its wraps moves an 8-bit countdown one step lower. When the countdown runs out it reloads the programmed timeout and a 2-bit stage counter moves up. The first three expirations can each raise a one-cycle interrupt. The fourth expiration raises a system reset request, which stays high until the block itself is reset.

Software arms the watchdog by writing the start bit of the command register. It writes that same bit again as the keep-alive, which reloads the countdown and clears the stage counter. A disable command is obeyed only when the write just before it placed the magic value 0xC45A in the key register. Any command write uses up that unlock. A key write of any other value takes it away.

Top module: `escalating_watchdog`

## Requirements
- R1: After reset, every readable register reads 0, the countdown is stopped, and `irq` and `rst_req` are low.
- R2: The register map is byte-addressed as follows:
  - Offset 0x0 is the configuration register. Bits [11:4] hold the timeout, bit 12 enables the interrupt, bit 15 enables the reset request, and bits [3:0] hold a timer-select tag that has no effect. It reads back as written.
  - Offset 0x4 is the status register. It reads the live countdown in bits [11:4] and the stage counter in bits [13:12].
- R3: The tick register sits at offset 0x10. Bit 31 enables the tick generator, bit 30 selects periodic mode, and the low bits hold the reload value. While enabled, the generator emits one watchdog tick every reload-value 1 MHz enables. In non-periodic mode it emits one tick and then clears its own enable bit. Writing this register restarts its phase.
- R4: While the watchdog runs, each tick lowers the countdown by one. A tick that arrives while the countdown is 1 is an expiration: the countdown reloads the timeout and the stage counter increments.
- R5: Writing bit 0 at command offset 0x8 loads the full timeout, clears the stage counter and starts the countdown. This holds whether or not the watchdog is already running, and a start in the same write as a disable wins.
- R6: Writing bit 1 at offset 0x8 stops the countdown only if the immediately preceding write to offset 0x8 or 0xC was 0xC45A to offset 0xC. A stopped countdown keeps its value.
- R7: With the interrupt enabled, `irq` is high for exactly one cycle after each of the first, second and third expirations. It never goes high otherwise.
- R8: On the fourth expiration the stage counter wraps to 0. If reset is enabled, `rst_req` rises and stays high through later commands until `rst_n` is asserted.
- R9: Clearing the tick enable freezes the countdown and the stage counter without clearing them.
- R10: The largest timeout, 255, loads in full and reads back as 0xFF in the countdown field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | 1 MHz enable strobe, one cycle wide |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-cycle pulse on each early expiration |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with `TMR_W` set to 8 and programs a reload value of 2, so one watchdog tick follows every two strobes. At that rate all four stages, the sticky reset request and the frozen-count cases are reached within a few dozen strobes. It also loads timeouts of 1 and 255, which cover both the smallest countdown and the widest field.

// File: rtl/escalating_watchdog.sv
module escalating_watchdog #(
  parameter int          ADDR_W = 5,
  parameter int          TMR_W  = 30,
  parameter logic [15:0] MAGIC  = 16'hC45A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(5'h10);

  logic [3:0]       cfg_sel;
  logic [7:0]       cfg_period;
  logic             cfg_irq_en, cfg_rst_en;
  logic             tmr_en, tmr_per;
  logic [TMR_W-1:0] tmr_reload, tmr_cnt;
  logic             running, unlocked;
  logic [7:0]       count;
  logic [1:0]       stage;

  wire wr_cfg = bus_we && bus_addr == A_CFG;
  wire wr_cmd = bus_we && bus_addr == A_CMD;
  wire wr_key = bus_we && bus_addr == A_KEY;
  wire wr_tmr = bus_we && bus_addr == A_TMR;
  wire start  = wr_cmd && bus_wdata[0];
  wire stop   = wr_cmd && bus_wdata[1] && unlocked;

  wire tmr_step = tmr_en && tick_us && tmr_reload != '0;
  wire wd_tick  = tmr_step && tmr_cnt == tmr_reload - TMR_W'(1);
  wire expire   = running && wd_tick && count <= 8'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {tmr_en, tmr_per} <= 2'b00;
      tmr_reload <= '0;
      tmr_cnt    <= '0;
    end else if (wr_tmr) begin
      tmr_en     <= bus_wdata[31];
      tmr_per    <= bus_wdata[30];
      tmr_reload <= bus_wdata[TMR_W-1:0];
      tmr_cnt    <= '0;
    end else if (tmr_step) begin
      if (wd_tick) begin
        tmr_cnt <= '0;
        if (!tmr_per) tmr_en <= 1'b0;
      end else begin
        tmr_cnt <= tmr_cnt + TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_sel <= '0; cfg_period <= '0; cfg_irq_en <= 1'b0; cfg_rst_en <= 1'b0;
    end else if (wr_cfg) begin
      cfg_sel    <= bus_wdata[3:0];
      cfg_period <= bus_wdata[11:4];
      cfg_irq_en <= bus_wdata[12];
      cfg_rst_en <= bus_wdata[15];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) unlocked <= 1'b0;
    else if (wr_key) unlocked <= bus_wdata == {16'h0, MAGIC};
    else if (wr_cmd) unlocked <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; count <= '0; stage <= '0; irq <= 1'b0; rst_req <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        running <= 1'b1;
        count   <= cfg_period;
        stage   <= '0;
      end else if (stop) begin
        running <= 1'b0;
      end else if (running && wd_tick) begin
        if (expire) begin
          count <= cfg_period;
          stage <= stage + 2'd1;
          if (stage == 2'd3) rst_req <= rst_req | cfg_rst_en;
          else irq <= cfg_irq_en;
        end else begin
          count <= count - 8'd1;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {16'h0, cfg_rst_en, 2'b00, cfg_irq_en, cfg_period, cfg_sel};
      A_STS:   bus_rdata = {18'h0, stage, count, 4'h0};
      A_TMR:   bus_rdata = {tmr_en, tmr_per, 30'(tmr_reload)};
      default: bus_rdata = '0;
    endcase
  end

  // R7
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7
  irq_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stage != 2'd0);
  // R8
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !wr_cmd) |=> ($stable(count) && $stable(stage)));
  // R6
  locked_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !unlocked) |=> running);
endmodule

// File: tb/escalating_watchdog_test.sv
module escalating_watchdog_test;
  logic        clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  escalating_watchdog #(.TMR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req));

  always #4 clk = ~clk;

  typedef struct { int kind; logic [31:0] val; string tag; } item_t;
  item_t q[$];
  event  smp;
  int    n_run = 0, n_fail = 0;
  bit    done = 1'b0;

  always begin
    @(smp);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.kind == 0 ? bus_rdata : it.kind == 1 ? 32'(irq) : 32'(rst_req);
      n_run++;
      if (act !== it.val) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
      end
    end
  end

  task automatic chk(input int kind, input logic [4:0] a, input logic [31:0] v, input string tag);
    item_t it;
    bus_addr = a;
    #1;
    it.kind = kind; it.val = v; it.tag = tag;
    q.push_back(it);
    ->smp;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1'b1;
      @(negedge clk);
    end
    tick_us = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(0, 5'h04, 32'h0, "R1 status");
    chk(0, 5'h00, 32'h0, "R1 cfg");
    chk(1, 5'h00, 32'h0, "R1 irq");
    chk(2, 5'h00, 32'h0, "R1 rst_req");

    wr(5'h10, 32'hC000_0002);
    wr(5'h00, 32'h0000_9035);
    wr(5'h08, 32'h1);
    chk(0, 5'h00, 32'h0000_9035, "R2 cfg readback");
    chk(0, 5'h10, 32'hC000_0002, "R3 timer readback");
    chk(0, 5'h04, 32'h30, "R5 start loads timeout");
    ticks(2);
    chk(0, 5'h04, 32'h20, "R3 one tick per reload");
    ticks(4);
    chk(1, 5'h00, 32'h1, "R7 irq on first expiration");
    chk(1, 5'h00, 32'h0, "R7 irq one cycle");
    chk(0, 5'h04, 32'h1030, "R4 expiration reload and stage");

    wr(5'h08, 32'h1);
    chk(0, 5'h04, 32'h30, "R5 ping clears stage");
    wr(5'h08, 32'h2);
    ticks(2);
    chk(0, 5'h04, 32'h20, "R6 stop without unlock ignored");
    wr(5'h0C, 32'hC45A);
    wr(5'h08, 32'h1);
    wr(5'h08, 32'h2);
    ticks(2);
    chk(0, 5'h04, 32'h20, "R6 unlock consumed by ping");
    wr(5'h0C, 32'h1234);
    wr(5'h08, 32'h2);
    ticks(2);
    chk(0, 5'h04, 32'h10, "R6 wrong key ignored");
    wr(5'h0C, 32'hC45A);
    wr(5'h08, 32'h2);
    ticks(6);
    chk(0, 5'h04, 32'h10, "R6 unlocked stop holds count");

    wr(5'h08, 32'h1);
    wr(5'h10, 32'h4000_0002);
    ticks(6);
    chk(0, 5'h04, 32'h30, "R9 disabled timer freezes");
    wr(5'h10, 32'hC000_0002);

    ticks(18);
    chk(1, 5'h00, 32'h1, "R7 irq on third expiration");
    chk(0, 5'h04, 32'h3030, "R4 stage three");
    chk(2, 5'h00, 32'h0, "R8 no reset before fourth");
    ticks(6);
    chk(1, 5'h00, 32'h0, "R7 no irq on fourth");
    chk(2, 5'h00, 32'h1, "R8 reset on fourth");
    chk(0, 5'h04, 32'h30, "R8 stage wraps");
    wr(5'h08, 32'h1);
    chk(2, 5'h00, 32'h1, "R8 reset sticky across ping");

    wr(5'h00, 32'h0000_9FF5);
    wr(5'h08, 32'h1);
    chk(0, 5'h04, 32'h0FF0, "R10 timeout 255");

    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(2, 5'h00, 32'h0, "R8 reset clears request");
    chk(0, 5'h04, 32'h0, "R1 status after reset");

    wr(5'h10, 32'hC000_0002);
    wr(5'h00, 32'h0000_0010);
    wr(5'h08, 32'h1);
    ticks(2);
    chk(1, 5'h00, 32'h0, "R7 irq disabled");
    chk(0, 5'h04, 32'h1010, "R4 timeout one expires each tick");
    ticks(6);
    chk(2, 5'h00, 32'h0, "R8 reset disabled");
    chk(0, 5'h04, 32'h0010, "R8 stage wraps without reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule